// File: doc/BRIEF.md
# Three-Stage Pipeline Branch Sequencer

This block sequences an in-order pipeline of three stages: fetch, decode and execute. It owns the fetch address and the valid bit and address of each stage. It moves one instruction per clock from stage to stage, so an instruction spends three cycles in the pipe while one instruction completes per cycle. The memory returns `instr_vld_i` for the word at `fetch_addr_o`. When that signal is low the fetch address holds and a bubble enters decode.

The execute datapath resolves branches. It raises `br_i` with a target and with a flag that picks the branch kind. A delayed branch lets the two instructions already behind it, in decode and fetch, finish in execute as delay slots. A flushing branch discards those two instructions. In both cases the target is driven to fetch in the cycle after resolution and reaches execute three cycles after the branch. If a branch resolves while execute holds a delay slot, the block reports it as illegal and treats it as a no-op.

Top module: `brseq_pipe_ctl`

## Requirements
- R1: While `rst_n` is low, `fetch_addr_o` equals `BOOT_ADDR`, and `vld_d_o`, `vld_e_o`, `slot_e_o` and `br_illegal_o` (with `br_i` low) are all 0.
- R2: With no branch taken, a word accepted at fetch address x in cycle t shows in decode (`vld_d_o`=1, `dec_addr_o`=x) in cycle t+1 and in execute (`vld_e_o`=1, `exe_addr_o`=x) in cycle t+2. The fetch address steps by one per accepted word, modulo 2^AW.
- R3: In a cycle with `instr_vld_i` low and no branch taken, the fetch address holds. Decode is invalid in the next cycle and execute is invalid one cycle after that.
- R4: `br_i` takes effect only when execute holds a valid instruction that is not a delay slot. While execute is invalid it has no effect and `br_illegal_o` stays 0.
- R5: A delayed branch (`br_delayed_i`=1) drives the target on `fetch_addr_o` in the next cycle. The instructions that sat in decode and fetch enter execute in the next two cycles with `slot_e_o`=1, in program order. The target reaches execute three cycles after resolution.
- R6: A flushing branch (`br_delayed_i`=0) drives the target on `fetch_addr_o` in the next cycle with decode and execute invalid. Execute stays invalid for two cycles, and the target reaches execute three cycles after resolution.
- R7: A branch that resolves while execute holds a delay slot sets `br_illegal_o` in that same cycle. It changes neither the fetch address nor the stages, and the first branch's sequence goes on unchanged.
- R8: `slot_e_o` is 1 only for the two instructions that follow an accepted delayed branch, and 0 for the target and every other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_vld_i | input | 1 | Memory has returned the word at the fetch address this cycle |
| br_i | input | 1 | Execute resolves a taken branch this cycle |
| br_delayed_i | input | 1 | 1 selects the delayed kind, 0 selects the flushing kind |
| br_target_i | input | AW | Branch target address |
| fetch_addr_o | output | AW | Address being fetched |
| vld_f_o | output | 1 | Fetch stage holds a valid word |
| vld_d_o | output | 1 | Decode stage holds a valid instruction |
| vld_e_o | output | 1 | Execute stage holds a valid instruction |
| dec_addr_o | output | AW | Address of the decode instruction |
| exe_addr_o | output | AW | Address of the execute instruction |
| slot_e_o | output | 1 | Execute instruction is a delay slot |
| br_illegal_o | output | 1 | Branch resolved inside a delay slot and was ignored |

## Verification
The bench resolves both branch kinds from several positions and to targets that include the top of the address space, where the fetch address wraps to zero. A design that flushed on a delayed branch would show empty execute cycles where the slots belong. A design that let a slot branch through would jump to the second target. Further sweeps raise a branch while execute is empty after a flush, and stall fetch for one to three cycles. These catch a block that acts on a dead instruction or lets the fetch address move past a word that was never returned.

// File: rtl/brseq_pkg.sv
package brseq_pkg;
    localparam int unsigned ADDR_W = 16;
    // stages after fetch: decode and execute; also the number of delay slots
    localparam int unsigned POST_FETCH = 2;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_DELAY   = 2'd1,
        ACT_FLUSH   = 2'd2,
        ACT_ILLEGAL = 2'd3
    } br_act_e;
endpackage

// File: rtl/brseq_resolve.sv
module brseq_resolve
    import brseq_pkg::*;
(
    input  logic    br_i,
    input  logic    br_delayed_i,
    input  logic    ex_vld_i,
    input  logic    ex_slot_i,
    output br_act_e act_o
);
    // a branch is honoured only from a live, non-slot execute instruction
    always_comb begin
        if (!br_i || !ex_vld_i) begin
            act_o = ACT_NONE;
        end else if (ex_slot_i) begin
            act_o = ACT_ILLEGAL;
        end else if (br_delayed_i) begin
            act_o = ACT_DELAY;
        end else begin
            act_o = ACT_FLUSH;
        end
    end
endmodule

// File: rtl/brseq_pc.sv
module brseq_pc
    import brseq_pkg::*;
#(
    parameter int unsigned    AW        = ADDR_W,
    parameter logic [AW-1:0]  BOOT_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  br_act_e       act_i,
    input  logic [AW-1:0] target_i,
    input  logic          instr_vld_i,
    output logic [AW-1:0] pc_o
);
    typedef struct packed {
        logic [AW-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act_i)
            ACT_DELAY, ACT_FLUSH: st_d.pc = target_i;
            default: begin
                if (instr_vld_i) begin
                    st_d.pc = st_q.pc + AW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc <= BOOT_ADDR;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;
endmodule

// File: rtl/brseq_stages.sv
module brseq_stages
    import brseq_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  br_act_e       act_i,
    input  logic          instr_vld_i,
    input  logic [AW-1:0] pc_i,
    output logic          vld_d_o,
    output logic          vld_e_o,
    output logic          slot_e_o,
    output logic [AW-1:0] dec_addr_o,
    output logic [AW-1:0] exe_addr_o
);
    localparam int unsigned NSTG = POST_FETCH;
    localparam int unsigned LAST = NSTG - 1;

    typedef struct packed {
        logic          vld;
        logic          slot;
        logic [AW-1:0] addr;
    } stg_t;

    stg_t [NSTG-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0].vld  = instr_vld_i;
        stg_d[0].slot = 1'b0;
        stg_d[0].addr = pc_i;
        for (int k = 1; k < NSTG; k++) begin
            stg_d[k] = stg_q[k-1];
        end
        unique case (act_i)
            ACT_FLUSH: begin
                for (int k = 0; k < NSTG; k++) begin
                    stg_d[k].vld  = 1'b0;
                    stg_d[k].slot = 1'b0;
                end
            end
            ACT_DELAY: begin
                for (int k = 0; k < NSTG; k++) begin
                    stg_d[k].slot = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign vld_d_o    = stg_q[0].vld;
    assign dec_addr_o = stg_q[0].addr;
    assign vld_e_o    = stg_q[LAST].vld;
    assign slot_e_o   = stg_q[LAST].vld & stg_q[LAST].slot;
    assign exe_addr_o = stg_q[LAST].addr;
endmodule

// File: rtl/brseq_pipe_ctl.sv
module brseq_pipe_ctl
    import brseq_pkg::*;
#(
    parameter int unsigned   AW        = ADDR_W,
    parameter logic [AW-1:0] BOOT_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_vld_i,
    input  logic          br_i,
    input  logic          br_delayed_i,
    input  logic [AW-1:0] br_target_i,
    output logic [AW-1:0] fetch_addr_o,
    output logic          vld_f_o,
    output logic          vld_d_o,
    output logic          vld_e_o,
    output logic [AW-1:0] dec_addr_o,
    output logic [AW-1:0] exe_addr_o,
    output logic          slot_e_o,
    output logic          br_illegal_o
);
    br_act_e act;
    logic    ex_vld;
    logic    ex_slot;

    brseq_resolve u_resolve (
        .br_i         (br_i),
        .br_delayed_i (br_delayed_i),
        .ex_vld_i     (ex_vld),
        .ex_slot_i    (ex_slot),
        .act_o        (act)
    );

    brseq_pc #(.AW(AW), .BOOT_ADDR(BOOT_ADDR)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .target_i    (br_target_i),
        .instr_vld_i (instr_vld_i),
        .pc_o        (fetch_addr_o)
    );

    brseq_stages #(.AW(AW)) u_stages (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .instr_vld_i (instr_vld_i),
        .pc_i        (fetch_addr_o),
        .vld_d_o     (vld_d_o),
        .vld_e_o     (ex_vld),
        .slot_e_o    (ex_slot),
        .dec_addr_o  (dec_addr_o),
        .exe_addr_o  (exe_addr_o)
    );

    assign vld_f_o      = instr_vld_i;
    assign vld_e_o      = ex_vld;
    assign slot_e_o     = ex_slot;
    assign br_illegal_o = (act == ACT_ILLEGAL);
endmodule

// File: rtl/brseq_pipe_ctl_chk.sv
module brseq_pipe_ctl_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_vld_i,
    input logic          br_i,
    input logic          br_delayed_i,
    input logic [AW-1:0] br_target_i,
    input logic [AW-1:0] fetch_addr_o,
    input logic          vld_d_o,
    input logic          vld_e_o,
    input logic [AW-1:0] dec_addr_o,
    input logic [AW-1:0] exe_addr_o,
    input logic          slot_e_o,
    input logic          br_illegal_o
);
    logic taken;
    assign taken = br_i && vld_e_o && !slot_e_o;

    // R2
    dec_to_exe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_d_o && !taken) |=> (vld_e_o && exe_addr_o == $past(dec_addr_o)));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_vld_i && !taken) |=> (fetch_addr_o == $past(fetch_addr_o) && !vld_d_o));

    // R5
    delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && br_delayed_i) |=> (fetch_addr_o == $past(br_target_i)
            && vld_e_o == $past(vld_d_o) && slot_e_o == $past(vld_d_o)));

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !br_delayed_i) |=> (fetch_addr_o == $past(br_target_i)
            && !vld_d_o && !vld_e_o));

    // R7
    illegal_noredir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_illegal_o && instr_vld_i) |=> (fetch_addr_o == AW'($past(fetch_addr_o) + 1'b1)));

    // R7
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_i && vld_e_o && slot_e_o) |-> br_illegal_o);

    // R4
    idle_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_i && !vld_e_o) |-> !br_illegal_o);

    // R8
    slot_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_e_o) |-> $past(taken && br_delayed_i));
endmodule

bind brseq_pipe_ctl brseq_pipe_ctl_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_vld_i  (instr_vld_i),
    .br_i         (br_i),
    .br_delayed_i (br_delayed_i),
    .br_target_i  (br_target_i),
    .fetch_addr_o (fetch_addr_o),
    .vld_d_o      (vld_d_o),
    .vld_e_o      (vld_e_o),
    .dec_addr_o   (dec_addr_o),
    .exe_addr_o   (exe_addr_o),
    .slot_e_o     (slot_e_o),
    .br_illegal_o (br_illegal_o)
);

// File: tb/brseq_pipe_ctl_bench.sv
`timescale 1ns/1ps
module brseq_pipe_ctl_bench;
    localparam int unsigned AW   = 8;
    localparam logic [7:0]  BOOT = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_vld_i = 1'b0;
    logic          br_i = 1'b0;
    logic          br_delayed_i = 1'b0;
    logic [AW-1:0] br_target_i = '0;
    logic [AW-1:0] fetch_addr_o;
    logic          vld_f_o, vld_d_o, vld_e_o, slot_e_o, br_illegal_o;
    logic [AW-1:0] dec_addr_o, exe_addr_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    brseq_pipe_ctl #(.AW(AW), .BOOT_ADDR(BOOT)) u_brseq_pipe_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_vld_i  (instr_vld_i),
        .br_i         (br_i),
        .br_delayed_i (br_delayed_i),
        .br_target_i  (br_target_i),
        .fetch_addr_o (fetch_addr_o),
        .vld_f_o      (vld_f_o),
        .vld_d_o      (vld_d_o),
        .vld_e_o      (vld_e_o),
        .dec_addr_o   (dec_addr_o),
        .exe_addr_o   (exe_addr_o),
        .slot_e_o     (slot_e_o),
        .br_illegal_o (br_illegal_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; instr_vld_i = 1'b0; br_i = 1'b0;
        tick(); tick();
        chk("R1 fetch", fetch_addr_o, BOOT);
        chk("R1 vld_d", vld_d_o, 0);
        chk("R1 vld_e", vld_e_o, 0);
        chk("R1 slot", slot_e_o, 0);
        chk("R1 illegal", br_illegal_o, 0);
        rst_n = 1'b1; instr_vld_i = 1'b1;
    endtask

    // one branch from execute address BOOT+k-2; extra = 1 or 2 adds a second
    // branch in the cycle j after resolution
    task automatic run_branch(input int k, input bit dly, input logic [7:0] tgt, input int extra);
        logic [7:0] a;
        do_reset();
        repeat (k) tick();
        a = 8'(BOOT + k - 2);
        chk("R2 fetch", fetch_addr_o, 8'(BOOT + k));
        chk("R2 dec", {vld_d_o, dec_addr_o}, {1'b1, 8'(BOOT + k - 1)});
        chk("R2 exe", {vld_e_o, exe_addr_o}, {1'b1, a});
        br_i = 1'b1; br_delayed_i = dly; br_target_i = tgt;
        #1 chk("R4 legal branch", br_illegal_o, 0);
        tick();
        br_i = 1'b0;
        for (int j = 1; j <= 4; j++) begin
            if (extra == j) begin
                br_i = 1'b1; br_delayed_i = ~dly; br_target_i = tgt ^ 8'h55;
                #1;
                if (dly) chk("R7 illegal flag", br_illegal_o, 1);
                else     chk("R4 idle branch", br_illegal_o, 0);
            end
            if (dly) begin
                case (j)
                    1: begin
                        chk("R5 fetch", fetch_addr_o, tgt);
                        chk("R5 exe slot1", {vld_e_o, slot_e_o, exe_addr_o}, {2'b11, 8'(a + 1)});
                        chk("R5 dec slot2", {vld_d_o, dec_addr_o}, {1'b1, 8'(a + 2)});
                    end
                    2: begin
                        chk("R5 fetch", fetch_addr_o, 8'(tgt + 1));
                        chk("R5 exe slot2", {vld_e_o, slot_e_o, exe_addr_o}, {2'b11, 8'(a + 2)});
                        chk("R5 dec target", {vld_d_o, dec_addr_o}, {1'b1, tgt});
                    end
                    3: begin
                        chk("R5 fetch", fetch_addr_o, 8'(tgt + 2));
                        chk("R8 exe target", {vld_e_o, slot_e_o, exe_addr_o}, {2'b10, tgt});
                    end
                    default:
                        chk("R8 exe after", {vld_e_o, slot_e_o, exe_addr_o}, {2'b10, 8'(tgt + 1)});
                endcase
            end else begin
                case (j)
                    1: begin
                        chk("R6 fetch", fetch_addr_o, tgt);
                        chk("R6 squash", {vld_d_o, vld_e_o}, 2'b00);
                    end
                    2: begin
                        chk("R6 fetch", fetch_addr_o, 8'(tgt + 1));
                        chk("R6 exe bubble", vld_e_o, 0);
                        chk("R6 dec target", {vld_d_o, dec_addr_o}, {1'b1, tgt});
                    end
                    3: begin
                        chk("R6 fetch", fetch_addr_o, 8'(tgt + 2));
                        chk("R6 exe target", {vld_e_o, slot_e_o, exe_addr_o}, {2'b10, tgt});
                    end
                    default:
                        chk("R2 exe after", {vld_e_o, slot_e_o, exe_addr_o}, {2'b10, 8'(tgt + 1)});
                endcase
            end
            tick();
            br_i = 1'b0;
        end
    endtask

    task automatic run_stall(input int k, input int gap);
        do_reset();
        repeat (k) tick();
        instr_vld_i = 1'b0;
        for (int g = 1; g <= gap; g++) begin
            tick();
            chk("R3 fetch hold", fetch_addr_o, 8'(BOOT + k));
            chk("R3 dec bubble", vld_d_o, 0);
            if (g == 1) chk("R3 exe", {vld_e_o, exe_addr_o}, {1'b1, 8'(BOOT + k - 1)});
            else        chk("R3 exe bubble", vld_e_o, 0);
        end
        instr_vld_i = 1'b1;
        tick();
        chk("R3 fetch resume", fetch_addr_o, 8'(BOOT + k + 1));
        chk("R3 dec resume", {vld_d_o, dec_addr_o}, {1'b1, 8'(BOOT + k)});
        chk("R3 exe bubble", vld_e_o, 0);
        tick();
        chk("R3 exe resume", {vld_e_o, exe_addr_o}, {1'b1, 8'(BOOT + k)});
    endtask

    initial begin
        logic [7:0] tgts [4] = '{8'h40, 8'hFE, 8'hFF, 8'h00};
        for (int k = 2; k <= 5; k += 3) begin
            for (int d = 0; d < 2; d++) begin
                for (int t = 0; t < 4; t++) begin
                    for (int x = 0; x < 3; x++) begin
                        run_branch(k, d[0], tgts[t], x);
                    end
                end
            end
        end
        for (int k = 2; k <= 4; k++) begin
            for (int g = 1; g <= 3; g++) begin
                run_stall(k, g);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule